// File: doc/BRIEF.md
# Interrupt Source PQ State Controller

This block keeps a two-bit state code, P (bit 1) and Q (bit 0), for each of a parameterized number of interrupt sources (128 by default). Software reaches the state only through a memory-mapped window. Each source owns a pair of adjacent 64 KiB pages: a trigger page followed by an end-of-interrupt (EOI) page. Loads at a few fixed page offsets return or overwrite the state. A store to the trigger page fires the source, and a store at one offset of the EOI page closes an interrupt.

When a trigger or an EOI should reach the routing logic downstream, the block emits a single-cycle notify pulse carrying the source index. The four state codes are 00 (reset, armed), 01 (off), 10 (pending) and 11 (queued, a second trigger arrived while pending). The load/store port accepts one request per cycle with no back-pressure. Load data and notify pulses appear one cycle after the request.

Top module: `pq_source_ctrl`

## Requirements
- R1: After reset every source holds PQ = 01 (off), and rd_valid and notify_valid are low.
- R2: The source index is req_addr[23:17], bit 16 selects the page (0 trigger, 1 EOI), and bits 15:0 are the page offset. State-access loads behave the same on either page.
- R3: A load at offset 0x800 sets rd_valid in the next cycle with rd_data = current PQ (P in bit 1, Q in bit 0), and leaves the state unchanged.
- R4: A load at offset 0xC00, 0xD00, 0xE00 or 0xF00 sets PQ to 00, 01, 10 or 11 respectively, and returns the PQ held before the update.
- R5: A load at any other offset returns rd_data = 00 and leaves the state unchanged.
- R6: A store at any offset of the trigger page does the following: 00 becomes 10 with a notify; 10 becomes 11 with no notify; 11 stays 11 with no notify; 01 stays 01 with no notify.
- R7: A store at offset 0x400 of the EOI page performs EOI: 10 becomes 00; 11 becomes 10 with a notify; 00 and 01 are unchanged; none of these except 11 notifies.
- R8: A store to the EOI page at any offset other than 0x400 has no effect on state or outputs.
- R9: A notify appears as notify_valid high for one cycle, in the cycle after the store, with notify_src equal to the source index. Stores never raise rd_valid.
- R10: A request changes only the addressed source. A request issued in the cycle right after another sees the state left by the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 24 | Window address: source, page, offset |
| rd_valid | output | 1 | Load response valid |
| rd_data | output | 2 | Load response, PQ code |
| notify_valid | output | 1 | Forward-notification pulse |
| notify_src | output | 7 | Source index of the notification |

## Verification
The bench walks one source through every transition without idle cycles. This exposes a design that reads stale state after an update, or that notifies from the off state or on a repeated trigger. Set loads are checked for returning the old code rather than the new one. EOI from the queued state must re-notify, and a design that simply clears PQ there would lose the second event. Stores to the wrong EOI offset and loads at unknown offsets must leave the state intact, and a sloppy offset decode would corrupt it. A second source at the top index and an untouched one at index 0 reveal index slicing errors, and a reset in the middle of the run must return a modified source to off.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;
  typedef enum logic [1:0] {
    PQ_RESET  = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_PEND   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_t;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_GET  = 3'd1,
    OP_SET  = 3'd2,
    OP_ZERO = 3'd3,
    OP_TRIG = 3'd4,
    OP_EOI  = 3'd5
  } pq_op_t;

  localparam int PAGE_BITS = 16;
  localparam logic [PAGE_BITS-1:0] OFF_GET = 16'h0800;
  localparam logic [PAGE_BITS-1:0] OFF_EOI = 16'h0400;
endpackage

// File: rtl/pq_addr_decode.sv
module pq_addr_decode
  import pq_src_pkg::*;
#(
  parameter int SRC_W  = 7,
  localparam int ADDR_W = SRC_W + PAGE_BITS + 1
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output pq_op_t            op_o,
  output logic [SRC_W-1:0]  src_o,
  output pq_t               set_val_o
);
  logic [PAGE_BITS-1:0] off;
  logic                 eoi_page;

  assign off       = addr_i[PAGE_BITS-1:0];
  assign eoi_page  = addr_i[PAGE_BITS];
  assign src_o     = addr_i[ADDR_W-1:PAGE_BITS+1];
  assign set_val_o = pq_t'(off[9:8]);

  always_comb begin
    op_o = OP_IDLE;
    if (valid_i) begin
      if (write_i) begin
        if (!eoi_page)           op_o = OP_TRIG;
        else if (off == OFF_EOI) op_o = OP_EOI;
      end else begin
        if (off == OFF_GET)                                    op_o = OP_GET;
        else if (off[15:10] == 6'b000011 && off[7:0] == 8'h00) op_o = OP_SET;
        else                                                   op_o = OP_ZERO;
      end
    end
  end
endmodule

// File: rtl/pq_transition.sv
module pq_transition
  import pq_src_pkg::*;
(
  input  pq_op_t op_i,
  input  pq_t    cur_i,
  input  pq_t    set_val_i,
  output pq_t    nxt_o,
  output logic   wr_en_o,
  output logic   fire_o
);
  always_comb begin
    nxt_o   = cur_i;
    wr_en_o = 1'b0;
    fire_o  = 1'b0;
    unique case (op_i)
      OP_SET: begin
        nxt_o   = set_val_i;
        wr_en_o = 1'b1;
      end
      OP_TRIG: begin
        unique case (cur_i)
          PQ_RESET: begin nxt_o = PQ_PEND;   wr_en_o = 1'b1; fire_o = 1'b1; end
          PQ_PEND:  begin nxt_o = PQ_QUEUED; wr_en_o = 1'b1; end
          default:  ;
        endcase
      end
      OP_EOI: begin
        unique case (cur_i)
          PQ_PEND:   begin nxt_o = PQ_RESET; wr_en_o = 1'b1; end
          PQ_QUEUED: begin nxt_o = PQ_PEND;  wr_en_o = 1'b1; fire_o = 1'b1; end
          default:   ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pq_state_array.sv
module pq_state_array
  import pq_src_pkg::*;
#(
  parameter int NUM_SRC = 128,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [SRC_W-1:0]       wr_idx_i,
  input  pq_t                    wr_val_i,
  output logic [NUM_SRC-1:0][1:0] st_o
);
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_ent
    logic ld;
    assign ld = wr_en_i && (wr_idx_i == SRC_W'(k));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  st_o[k] <= PQ_OFF;
      else if (ld)  st_o[k] <= wr_val_i;
    end
  end
endmodule

// File: rtl/pq_source_ctrl.sv
module pq_source_ctrl
  import pq_src_pkg::*;
#(
  parameter int NUM_SRC = 128,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = SRC_W + PAGE_BITS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rd_valid,
  output logic [1:0]        rd_data,
  output logic              notify_valid,
  output logic [SRC_W-1:0]  notify_src
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pq_op_t                    dec_op;
  logic [SRC_W-1:0]          dec_src;
  pq_t                       dec_set;
  pq_t                       cur_st, nxt_st;
  logic                      st_we, fire;
  logic [NUM_SRC-1:0][1:0]   st_all;

  pq_addr_decode #(.SRC_W(SRC_W)) u_dec (
    .valid_i(req_valid), .write_i(req_write), .addr_i(req_addr),
    .op_o(dec_op), .src_o(dec_src), .set_val_o(dec_set)
  );

  assign cur_st = pq_t'(st_all[dec_src]);

  pq_transition u_fsm (
    .op_i(dec_op), .cur_i(cur_st), .set_val_i(dec_set),
    .nxt_o(nxt_st), .wr_en_o(st_we), .fire_o(fire)
  );

  pq_state_array #(.NUM_SRC(NUM_SRC)) u_arr (
    .clk(clk), .rst_ni(rst_ni), .wr_en_i(st_we),
    .wr_idx_i(dec_src), .wr_val_i(nxt_st), .st_o(st_all)
  );

  logic             rd_valid_d;
  logic [1:0]       rd_data_d;

  always_comb begin
    rd_valid_d = req_valid && !req_write;
    rd_data_d  = (dec_op == OP_GET || dec_op == OP_SET) ? cur_st : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid     <= 1'b0;
      rd_data      <= 2'b00;
      notify_valid <= 1'b0;
      notify_src   <= '0;
    end else begin
      rd_valid     <= rd_valid_d;
      notify_valid <= fire;
      if (rd_valid_d) rd_data    <= rd_data_d;
      if (fire)       notify_src <= dec_src;
    end
  end

  // R9
  ntf_after_store_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    notify_valid |-> $past(req_valid && req_write));

  // R3
  rd_after_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_valid |-> $past(req_valid && !req_write));

  // R6 R7
  ntf_pending_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    notify_valid |-> (st_all[notify_src] == PQ_PEND));

  // R3
  get_stable_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (dec_op == OP_GET) |=> (st_all[$past(dec_src)] == $past(cur_st)));
endmodule

// File: tb/tb_pq_source_ctrl.sv
module tb_pq_source_ctrl;
  localparam int CLK_NS = 20;

  typedef struct packed {
    logic        wr;
    logic [6:0]  src;
    logic        pg;
    logic [15:0] off;
    logic        rv;
    logic [1:0]  rd;
    logic        nv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 7'd3,   1'b1, 16'h0800, 1'b1, 2'b01, 1'b0, 8'd3},  // R3 off after reset
    '{1'b1, 7'd3,   1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 8'd6},  // R6 trigger while off
    '{1'b0, 7'd3,   1'b1, 16'h0800, 1'b1, 2'b01, 1'b0, 8'd6},  // R6 still off
    '{1'b0, 7'd3,   1'b1, 16'h0C00, 1'b1, 2'b01, 1'b0, 8'd4},  // R4 set 00 returns old
    '{1'b0, 7'd3,   1'b0, 16'h0800, 1'b1, 2'b00, 1'b0, 8'd2},  // R2 get on trigger page
    '{1'b1, 7'd3,   1'b0, 16'h0123, 1'b0, 2'b00, 1'b1, 8'd6},  // R6 00 -> 10 notify
    '{1'b0, 7'd3,   1'b1, 16'h0800, 1'b1, 2'b10, 1'b0, 8'd9},  // R9 single pulse
    '{1'b1, 7'd3,   1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 8'd6},  // R6 10 -> 11 silent
    '{1'b1, 7'd3,   1'b0, 16'h0000, 1'b0, 2'b00, 1'b0, 8'd6},  // R6 11 stays
    '{1'b0, 7'd3,   1'b1, 16'h0800, 1'b1, 2'b11, 1'b0, 8'd6},
    '{1'b1, 7'd3,   1'b1, 16'h0400, 1'b0, 2'b00, 1'b1, 8'd7},  // R7 11 -> 10 notify
    '{1'b0, 7'd3,   1'b1, 16'h0800, 1'b1, 2'b10, 1'b0, 8'd7},
    '{1'b1, 7'd3,   1'b1, 16'h0400, 1'b0, 2'b00, 1'b0, 8'd7},  // R7 10 -> 00
    '{1'b0, 7'd3,   1'b1, 16'h0800, 1'b1, 2'b00, 1'b0, 8'd7},
    '{1'b1, 7'd3,   1'b1, 16'h0400, 1'b0, 2'b00, 1'b0, 8'd7},  // R7 EOI in 00
    '{1'b0, 7'd3,   1'b1, 16'h0800, 1'b1, 2'b00, 1'b0, 8'd7},
    '{1'b0, 7'd3,   1'b1, 16'h0E00, 1'b1, 2'b00, 1'b0, 8'd4},  // R4 set 10
    '{1'b1, 7'd3,   1'b1, 16'h0000, 1'b0, 2'b00, 1'b0, 8'd8},  // R8 wrong EOI offset
    '{1'b1, 7'd3,   1'b1, 16'h0800, 1'b0, 2'b00, 1'b0, 8'd8},  // R8 wrong EOI offset
    '{1'b0, 7'd3,   1'b1, 16'h0800, 1'b1, 2'b10, 1'b0, 8'd8},  // R8 state intact
    '{1'b0, 7'd3,   1'b1, 16'h0F00, 1'b1, 2'b10, 1'b0, 8'd4},  // R4 set 11
    '{1'b0, 7'd3,   1'b1, 16'h0D00, 1'b1, 2'b11, 1'b0, 8'd4},  // R4 set 01
    '{1'b1, 7'd3,   1'b1, 16'h0400, 1'b0, 2'b00, 1'b0, 8'd7},  // R7 EOI in 01
    '{1'b0, 7'd3,   1'b1, 16'h0800, 1'b1, 2'b01, 1'b0, 8'd7},
    '{1'b0, 7'd127, 1'b1, 16'h0800, 1'b1, 2'b01, 1'b0, 8'd10}, // R10 other source
    '{1'b0, 7'd127, 1'b0, 16'h0C00, 1'b1, 2'b01, 1'b0, 8'd2},  // R2 set on trigger page
    '{1'b1, 7'd127, 1'b0, 16'h0000, 1'b0, 2'b00, 1'b1, 8'd9},  // R9 notify src 127
    '{1'b0, 7'd127, 1'b1, 16'h0900, 1'b1, 2'b00, 1'b0, 8'd5},  // R5 unknown offset
    '{1'b0, 7'd127, 1'b1, 16'h0800, 1'b1, 2'b10, 1'b0, 8'd5},  // R5 no change
    '{1'b0, 7'd0,   1'b1, 16'h0800, 1'b1, 2'b01, 1'b0, 8'd10}, // R10 untouched
    '{1'b0, 7'd3,   1'b1, 16'h0800, 1'b1, 2'b01, 1'b0, 8'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [23:0] req_addr;
  logic        rd_valid, notify_valid;
  logic [1:0]  rd_data;
  logic [6:0]  notify_src;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_NS/2) clk = ~clk;

  pq_source_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .notify_valid(notify_valid), .notify_src(notify_src)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [6:0] s, input logic pg, input logic [15:0] off);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = {s, pg, off};
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 idle outputs after reset
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "notify_valid", notify_valid, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row%0d", VEC[i].req, i);
      drive(VEC[i].wr, VEC[i].src, VEC[i].pg, VEC[i].off);
      chk(tag, "rd_valid", rd_valid, VEC[i].rv);
      if (VEC[i].rv) chk(tag, "rd_data", rd_data, VEC[i].rd);
      chk(tag, "notify_valid", notify_valid, VEC[i].nv);
      if (VEC[i].nv) chk(tag, "notify_src", notify_src, VEC[i].src);
    end

    // R9 pulse lasts one cycle only
    drive(1'b1, 7'd3, 1'b0, 16'h0000); // 01: silent
    drive(1'b0, 7'd3, 1'b1, 16'h0C00);
    drive(1'b1, 7'd3, 1'b0, 16'h0000);
    chk("R9", "notify_valid", notify_valid, 1);
    @(negedge clk);
    chk("R9", "notify_valid idle", notify_valid, 0);

    // R1 reset mid-run returns a modified source to off
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "notify_valid in reset", notify_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(1'b0, 7'd3, 1'b1, 16'h0800);
    chk("R1", "rd_data after reset", rd_data, 1);
    drive(1'b0, 7'd127, 1'b1, 16'h0800);
    chk("R1", "rd_data src127 after reset", rd_data, 1);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule